// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Arbiter

This block sits between a group of peripheral interrupt request lines and a CPU. A rising edge on a request line, or a software write, makes that line pending. Each line also has an enable bit and a programmable 8-bit priority field. From the pending, enabled and unmasked lines the arbiter picks one winner. It presents that winner to the CPU as a request flag, a vector index and the winner's priority field.

A configurable grouping value splits the three implemented priority bits into a preemption part and a subpriority part. Only the preemption part decides whether a new request may interrupt a handler that is already running. The CPU signals handler entry with an acknowledge pulse. That pulse clears the taken line's pending bit and pushes the line's preemption key onto a small nesting stack. A handler-exit pulse pops the stack.

A base-priority threshold blocks every level at or below a programmed value. A global CPU-side disable gates the request output and changes no stored state. Registers are written through a simple single-cycle write port and read through a combinational read port. Lower addresses hold the control values. Addresses with the MSB set select the priority field of line `addr[IDXW-1:0]`.

Top module: `prio_irq_arbiter`

## Requirements
- R1: After reset, the enable, pending, priority, grouping and base-mask values all read as zero and `cpu_irq` is low.
- R2: A priority write to address `N_IRQ + i` keeps only bits [7:5] of the written byte. A read returns those bits with bits [4:0] zero, so the only possible values are 0x00, 0x20, ..., 0xE0.
- R3: A line becomes pending on a 0-to-1 transition of its request input, or when a 1 is written to its bit at the pending-set address (1). A request held high does not re-pend the line after it is cleared. Reads at address 1 or 2 return the pending vector.
- R4: Writing a 1 to a line's bit at the pending-clear address (2) discards that line's unserviced request. A new edge arriving in the same cycle wins over the clear.
- R5: The winner is the pending, enabled, unmasked line with the numerically smallest 3-bit level (0 is most urgent). A tie goes to the lowest index. `cpu_vec` carries the winner's index and `cpu_level` carries its priority field.
- R6: A pending line whose enable bit (address 0, bit i) is 0 stays pending and is never presented.
- R7: A base-mask value B (address 4, bits [2:0]) of 0 masks nothing. A value of 1 to 7 blocks every line whose level is B or greater.
- R8: While `cpu_mask_all` is high, `cpu_irq` is low, and the enable and pending state is unchanged.
- R9: `cpu_ack` sampled with `cpu_irq` high clears the presented line's pending bit and makes that line's preemption key active. `cpu_ack` sampled with `cpu_irq` low has no effect.
- R10: Grouping G (address 3, bits [2:0]) sets how many upper level bits form the preemption key: G=0 gives none, G=1 gives one, G=2 gives two, and G=3 to 7 give all three. While a handler is active, a request is raised only if its key is strictly smaller than the active key.
- R11: A `cpu_exit` pulse releases the most recently activated key. Once no key is active, any winner is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | N_IRQ | Peripheral request lines, synchronous to clk |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW | Register address |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data (combinational) |
| cpu_mask_all | input | 1 | Global CPU-side interrupt disable |
| cpu_ack | input | 1 | Handler-entry acknowledge |
| cpu_exit | input | 1 | Handler-exit pulse |
| cpu_irq | output | 1 | Interrupt request to the CPU |
| cpu_vec | output | IDXW | Index of the presented line |
| cpu_level | output | 8 | Priority field of the presented line |

## Verification
The assertions assume a few things about the CPU-side inputs. `cpu_ack` and `cpu_exit` are never asserted in the same cycle. Every exit matches an earlier accepted entry. The request lines are already synchronous to the clock. The stimulus follows these rules by pulsing acknowledge and exit on separate falling edges, always in entry/exit pairs, and by driving every input on the falling edge. The nesting checks and the acknowledge-clears check compare state one cycle apart, so they rely on these rules holding.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

  localparam int LVL_W = 3;

  typedef logic [LVL_W-1:0] lvl_t;

  // control register addresses (lower half of the address space)
  typedef enum logic [2:0] {
    RA_ENABLE   = 3'd0,
    RA_PEND_SET = 3'd1,
    RA_PEND_CLR = 3'd2,
    RA_GROUP    = 3'd3,
    RA_BASE     = 3'd4
  } ctl_addr_e;

  // implemented level lives in the top three bits of the byte
  function automatic lvl_t field_to_lvl(input logic [7:0] f);
    return f[7:5];
  endfunction

  function automatic logic [7:0] lvl_to_field(input lvl_t l);
    return {l, 5'b0_0000};
  endfunction

  // preemption key: keep the upper G level bits, G saturating at three
  function automatic lvl_t preempt_key(input lvl_t l, input logic [2:0] g);
    lvl_t m;
    case (g)
      3'd0:    m = 3'b000;
      3'd1:    m = 3'b100;
      3'd2:    m = 3'b110;
      default: m = 3'b111;
    endcase
    return l & m;
  endfunction

  // base threshold: zero disables, otherwise levels >= threshold are blocked
  function automatic logic base_blocks(input lvl_t l, input lvl_t bm);
    return (bm != '0) && (l >= bm);
  endfunction

endpackage

// File: rtl/irq_arb_pend.sv
module irq_arb_pend #(
  parameter int N_IRQ = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IRQ-1:0] lines,
  input  logic [N_IRQ-1:0] sw_set,
  input  logic [N_IRQ-1:0] sw_clr,
  input  logic [N_IRQ-1:0] ack_clr,
  output logic [N_IRQ-1:0] raise_o,
  output logic [N_IRQ-1:0] pend_o
);

  for (genvar i = 0; i < N_IRQ; i++) begin : g_line
    logic prev_q;
    logic pend_q;
    logic raise;

    assign raise = (lines[i] & ~prev_q) | sw_set[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev_q <= 1'b0;
        pend_q <= 1'b0;
      end else begin
        prev_q <= lines[i];
        // a new raise beats any clear in the same cycle
        pend_q <= (pend_q & ~(sw_clr[i] | ack_clr[i])) | raise;
      end
    end

    assign raise_o[i] = raise;
    assign pend_o[i]  = pend_q;
  end

endmodule

// File: rtl/irq_arb_select.sv
module irq_arb_select
  import irq_arb_pkg::*;
#(
  parameter  int N_IRQ = 8,
  localparam int IDXW  = $clog2(N_IRQ)
) (
  input  logic [N_IRQ-1:0]       pend,
  input  logic [N_IRQ-1:0]       en,
  input  lvl_t [N_IRQ-1:0]       lvls,
  input  lvl_t                   base,
  output logic                   win_valid,
  output logic [IDXW-1:0]        win_idx,
  output lvl_t                   win_lvl
);

  logic [N_IRQ-1:0] cand;

  for (genvar i = 0; i < N_IRQ; i++) begin : g_cand
    assign cand[i] = pend[i] & en[i] & ~base_blocks(lvls[i], base);
  end

  // linear scan; strict compare keeps the lowest index on ties
  always_comb begin
    win_valid = 1'b0;
    win_idx   = '0;
    win_lvl   = '0;
    for (int i = 0; i < N_IRQ; i++) begin
      if (cand[i] && (!win_valid || (lvls[i] < win_lvl))) begin
        win_valid = 1'b1;
        win_idx   = IDXW'(i);
        win_lvl   = lvls[i];
      end
    end
  end

endmodule

// File: rtl/irq_arb_nest.sv
module irq_arb_nest
  import irq_arb_pkg::*;
#(
  parameter  int DEPTH = 8,
  localparam int CW    = $clog2(DEPTH + 1),
  localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  lvl_t          push_key,
  input  logic          pop,
  output logic          active,
  output lvl_t          top_key,
  output logic [CW-1:0] depth
);

  lvl_t          keys_q [DEPTH];
  logic [CW-1:0] cnt_q;
  logic          pop_eff;
  logic          push_eff;
  logic [CW-1:0] base_cnt;
  logic [PW-1:0] wr_idx;
  logic [PW-1:0] top_idx;

  assign pop_eff  = pop && (cnt_q != '0);
  assign base_cnt = cnt_q - CW'(pop_eff);
  assign push_eff = push && (base_cnt < CW'(DEPTH));
  assign wr_idx   = PW'(base_cnt);
  assign top_idx  = PW'(cnt_q - CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) keys_q[i] <= '0;
    end else begin
      if (push_eff) keys_q[wr_idx] <= push_key;
      cnt_q <= base_cnt + CW'(push_eff);
    end
  end

  assign active  = (cnt_q != '0);
  assign top_key = active ? keys_q[top_idx] : '0;
  assign depth   = cnt_q;

endmodule

// File: rtl/prio_irq_arbiter.sv
module prio_irq_arbiter
  import irq_arb_pkg::*;
#(
  parameter  int N_IRQ      = 8,
  parameter  int NEST_DEPTH = 8,
  localparam int IDXW       = $clog2(N_IRQ),
  localparam int AW         = IDXW + 1,
  localparam int DW         = (N_IRQ > 8) ? N_IRQ : 8,
  localparam int CW         = $clog2(NEST_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IRQ-1:0] irq_in,
  input  logic             reg_we,
  input  logic [AW-1:0]    reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  input  logic             cpu_mask_all,
  input  logic             cpu_ack,
  input  logic             cpu_exit,
  output logic             cpu_irq,
  output logic [IDXW-1:0]  cpu_vec,
  output logic [7:0]       cpu_level
);

  logic [N_IRQ-1:0] en_q;
  lvl_t [N_IRQ-1:0] lvl_q;
  logic [2:0]       grp_q;
  lvl_t             base_q;

  logic             is_prio;
  logic [IDXW-1:0]  prio_sel;
  logic             hit_en, hit_set, hit_clr, hit_grp, hit_base;
  logic [N_IRQ-1:0] sw_set, sw_clr, ack_clr;
  logic [N_IRQ-1:0] pend, raise;
  logic             win_valid;
  logic [IDXW-1:0]  win_idx;
  lvl_t             win_lvl;
  logic             active;
  lvl_t             top_key;
  logic [CW-1:0]    depth;
  logic             preempt_ok;
  logic             take;

  // address decode
  assign is_prio  = reg_addr[AW-1];
  assign prio_sel = reg_addr[IDXW-1:0];
  assign hit_en   = (reg_addr == AW'(RA_ENABLE));
  assign hit_set  = (reg_addr == AW'(RA_PEND_SET));
  assign hit_clr  = (reg_addr == AW'(RA_PEND_CLR));
  assign hit_grp  = (reg_addr == AW'(RA_GROUP));
  assign hit_base = (reg_addr == AW'(RA_BASE));

  assign sw_set  = (reg_we && hit_set) ? reg_wdata[N_IRQ-1:0] : '0;
  assign sw_clr  = (reg_we && hit_clr) ? reg_wdata[N_IRQ-1:0] : '0;
  assign take    = cpu_ack && cpu_irq;
  assign ack_clr = take ? (N_IRQ'(1) << cpu_vec) : '0;

  // configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      lvl_q  <= '0;
      grp_q  <= '0;
      base_q <= '0;
    end else if (reg_we) begin
      if (is_prio)  lvl_q[prio_sel] <= field_to_lvl(reg_wdata[7:0]);
      if (hit_en)   en_q            <= reg_wdata[N_IRQ-1:0];
      if (hit_grp)  grp_q           <= reg_wdata[2:0];
      if (hit_base) base_q          <= reg_wdata[2:0];
    end
  end

  irq_arb_pend #(.N_IRQ(N_IRQ)) pend_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .lines   (irq_in),
    .sw_set  (sw_set),
    .sw_clr  (sw_clr),
    .ack_clr (ack_clr),
    .raise_o (raise),
    .pend_o  (pend)
  );

  irq_arb_select #(.N_IRQ(N_IRQ)) sel_i (
    .pend      (pend),
    .en        (en_q),
    .lvls      (lvl_q),
    .base      (base_q),
    .win_valid (win_valid),
    .win_idx   (win_idx),
    .win_lvl   (win_lvl)
  );

  irq_arb_nest #(.DEPTH(NEST_DEPTH)) nest_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (take),
    .push_key (preempt_key(win_lvl, grp_q)),
    .pop      (cpu_exit),
    .active   (active),
    .top_key  (top_key),
    .depth    (depth)
  );

  assign preempt_ok = !active || (preempt_key(win_lvl, grp_q) < top_key);
  assign cpu_irq    = win_valid && preempt_ok && !cpu_mask_all;
  assign cpu_vec    = win_idx;
  assign cpu_level  = lvl_to_field(win_lvl);

  // read port
  always_comb begin
    reg_rdata = '0;
    if (is_prio)                 reg_rdata = DW'(lvl_to_field(lvl_q[prio_sel]));
    else if (hit_en)             reg_rdata = DW'(en_q);
    else if (hit_set || hit_clr) reg_rdata = DW'(pend);
    else if (hit_grp)            reg_rdata = DW'(grp_q);
    else if (hit_base)           reg_rdata = DW'(base_q);
  end

endmodule

// File: rtl/irq_arb_chk.sv
module irq_arb_chk #(
  parameter  int N_IRQ      = 8,
  parameter  int NEST_DEPTH = 8,
  localparam int IDXW       = $clog2(N_IRQ),
  localparam int CW         = $clog2(NEST_DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cpu_irq,
  input logic [IDXW-1:0]  cpu_vec,
  input logic [7:0]       cpu_level,
  input logic             cpu_mask_all,
  input logic             cpu_exit,
  input logic             take,
  input logic             active,
  input logic [N_IRQ-1:0] pend,
  input logic [N_IRQ-1:0] en_q,
  input logic [N_IRQ-1:0] raise,
  input logic [2:0]       grp_q,
  input logic [2:0]       base_q,
  input logic [2:0]       top_key,
  input logic [CW-1:0]    depth
);

  logic [1:0] psh;
  assign psh = (grp_q >= 3'd3) ? 2'd0 : 2'(3 - grp_q);

  AST_IRQ_IS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq |-> (pend[cpu_vec] && en_q[cpu_vec])); // R5

  AST_GLOBAL_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_mask_all |-> !cpu_irq); // R8

  AST_BASE_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_irq && (base_q != 3'd0)) |-> (cpu_level[7:5] < base_q)); // R7

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !raise[cpu_vec]) |=> !pend[$past(cpu_vec)]); // R9

  AST_NEST_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !cpu_exit) |=> (depth == CW'($past(depth) + 1'b1))); // R9

  AST_EXIT_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_exit && !take && active) |=> (depth == CW'($past(depth) - 1'b1))); // R11

  AST_PREEMPT_STRICT: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_irq && active) |-> ((cpu_level[7:5] >> psh) < (top_key >> psh))); // R10

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= CW'(NEST_DEPTH)); // R10

endmodule

bind prio_irq_arbiter irq_arb_chk #(.N_IRQ(N_IRQ), .NEST_DEPTH(NEST_DEPTH)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .cpu_irq      (cpu_irq),
  .cpu_vec      (cpu_vec),
  .cpu_level    (cpu_level),
  .cpu_mask_all (cpu_mask_all),
  .cpu_exit     (cpu_exit),
  .take         (take),
  .active       (active),
  .pend         (pend),
  .en_q         (en_q),
  .raise        (raise),
  .grp_q        (grp_q),
  .base_q       (base_q),
  .top_key      (top_key),
  .depth        (depth)
);

// File: tb/prio_irq_arbiter_tb_top.sv
`timescale 1ns/1ps
module prio_irq_arbiter_tb_top;

  localparam int N  = 8;
  localparam int AW = 4;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  irq_in = '0;
  logic          reg_we = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic          cpu_mask_all = 1'b0;
  logic          cpu_ack = 1'b0;
  logic          cpu_exit = 1'b0;
  logic          cpu_irq;
  logic [2:0]    cpu_vec;
  logic [7:0]    cpu_level;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int lv [N];

  always #2.5 clk = ~clk;

  prio_irq_arbiter dut_i (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cpu_mask_all(cpu_mask_all), .cpu_ack(cpu_ack), .cpu_exit(cpu_exit),
    .cpu_irq(cpu_irq), .cpu_vec(cpu_vec), .cpu_level(cpu_level)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = AW'(a); reg_wdata = DW'(d);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    reg_addr = AW'(a);
    #1;
    d = int'(reg_rdata);
  endtask

  task automatic pulse_ack();
    @(negedge clk); cpu_ack = 1'b1;
    @(negedge clk); cpu_ack = 1'b0;
  endtask

  task automatic pulse_exit();
    @(negedge clk); cpu_exit = 1'b1;
    @(negedge clk); cpu_exit = 1'b0;
  endtask

  // bench-side preemption key: drop the subpriority bits by shifting
  function automatic int bkey(input int l, input int g);
    int gg = (g > 3) ? 3 : g;
    return l >> (3 - gg);
  endfunction

  task automatic model_win(input int pm, input int em, input int bm,
                           output bit v, output int idx, output int l);
    v = 0; idx = 0; l = 99;
    for (int i = 0; i < N; i++) begin
      bit live = pm[i] && em[i] && !(bm != 0 && lv[i] >= bm);
      if (live && lv[i] < l) begin v = 1; idx = i; l = lv[i]; end
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int d;
    bit v;
    int idx, l;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 16; a++) begin
      rd(a, d);
      chk(d == 0, "R1 reset register", d, 0);
    end
    chk(cpu_irq == 0, "R1 reset cpu_irq", cpu_irq, 0);

    // R2 exhaustive priority byte sweep
    for (int i = 0; i < N; i++)
      for (int p = 0; p < 256; p++) begin
        wr(8 + i, p);
        rd(8 + i, d);
        chk(d == (p & 8'hE0), "R2 priority readback", d, p & 8'hE0);
      end
    for (int i = 0; i < N; i++) wr(8 + i, 0);

    // R3 edge pending, held level does not re-pend
    @(negedge clk); irq_in[3] = 1'b1;
    @(negedge clk);
    rd(1, d); chk(d == 8'h08, "R3 edge sets pending", d, 8'h08);
    wr(2, 8'h08);
    repeat (3) @(negedge clk);
    rd(2, d); chk(d == 0, "R3 held line no re-pend", d, 0);
    irq_in[3] = 1'b0;
    @(negedge clk); irq_in[3] = 1'b1;
    @(negedge clk); irq_in[3] = 1'b0;
    rd(1, d); chk(d == 8'h08, "R3 second edge", d, 8'h08);
    wr(1, 8'h41);
    rd(1, d); chk(d == 8'h49, "R3 software set", d, 8'h49);

    // R4 clear discards; edge in the same cycle wins
    wr(2, 8'hFF);
    rd(1, d); chk(d == 0, "R4 clear discards", d, 0);
    @(negedge clk);
    irq_in[2] = 1'b1; reg_we = 1'b1; reg_addr = 2; reg_wdata = 8'h04;
    @(negedge clk);
    reg_we = 1'b0; irq_in[2] = 1'b0;
    rd(1, d); chk(d == 8'h04, "R4 edge beats clear", d, 8'h04);
    wr(2, 8'hFF);

    // R6 enable sweep with everything pending
    for (int i = 0; i < N; i++) lv[i] = 7 - i;
    for (int i = 0; i < N; i++) wr(8 + i, lv[i] << 5);
    wr(1, 8'hFF);
    for (int em = 0; em < 256; em++) begin
      wr(0, em);
      model_win(8'hFF, em, 0, v, idx, l);
      chk(cpu_irq == v, "R6 irq vs enable", cpu_irq, v);
      if (v) chk(int'(cpu_vec) == idx, "R6 vec vs enable", cpu_vec, idx);
      rd(1, d); chk(d == 8'hFF, "R6 disabled stays pending", d, 8'hFF);
    end
    wr(2, 8'hFF);

    // R5 / R7 winner sweep over level sets, base masks and patterns
    wr(0, 8'hFF);
    for (int s = 0; s < 4; s++) begin
      for (int i = 0; i < N; i++) begin
        case (s)
          0: lv[i] = 0;
          1: lv[i] = 7 - i;
          2: lv[i] = (i % 3) * 2;
          default: lv[i] = (i * 5 + 3) % 8;
        endcase
        wr(8 + i, (lv[i] << 5) | (i & 31));
      end
      for (int bm = 0; bm < 8; bm++) begin
        wr(4, bm);
        for (int pm = 1; pm < 256; pm++) begin
          wr(1, pm);
          model_win(pm, 8'hFF, bm, v, idx, l);
          chk(cpu_irq == v, "R7 irq vs base mask", cpu_irq, v);
          if (v) begin
            chk(int'(cpu_vec) == idx, "R5 winner index", cpu_vec, idx);
            chk(int'(cpu_level) == (l << 5), "R5 winner level", cpu_level, l << 5);
          end
          wr(2, 8'hFF);
        end
      end
    end
    wr(4, 0);

    // R8 global disable gates the output only
    wr(0, 8'h01);
    wr(1, 8'h01);
    @(negedge clk); cpu_mask_all = 1'b1;
    #1 chk(cpu_irq == 0, "R8 gated", cpu_irq, 0);
    rd(0, d); chk(d == 8'h01, "R8 enable kept", d, 8'h01);
    rd(1, d); chk(d == 8'h01, "R8 pending kept", d, 8'h01);
    // R9 ack while the request is low is ignored
    pulse_ack();
    rd(1, d); chk(d == 8'h01, "R9 ignored ack keeps pending", d, 8'h01);
    cpu_mask_all = 1'b0;
    #1 chk(cpu_irq == 1, "R8 released", cpu_irq, 1);
    pulse_ack();
    rd(1, d); chk(d == 0, "R9 ack clears pending", d, 0);
    chk(cpu_irq == 0, "R9 nothing left", cpu_irq, 0);
    pulse_exit();
    wr(2, 8'hFF);

    // R10 / R11 preemption sweep over grouping and level pairs
    wr(0, 8'h03);
    for (int g = 0; g < 8; g++) begin
      wr(3, g);
      rd(3, d); chk(d == g, "R10 grouping readback", d, g);
      for (int la = 0; la < 8; la++)
        for (int lb = 0; lb < 8; lb++) begin
          bit exp_pre;
          wr(8, la << 5);
          wr(9, lb << 5);
          wr(1, 8'h01);
          chk(cpu_irq == 1 && cpu_vec == 0, "R9 first request", cpu_vec, 0);
          pulse_ack();
          wr(1, 8'h02);
          exp_pre = bkey(lb, g) < bkey(la, g);
          chk(cpu_irq == exp_pre, "R10 preemption decision", cpu_irq, exp_pre);
          pulse_exit();
          chk(cpu_irq == 1 && cpu_vec == 1, "R11 exit releases", {cpu_irq, cpu_vec}, 4'b1001);
          wr(2, 8'hFF);
        end
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule